// File: doc/BRIEF.md
# Display Controller Reset and Power-Down Sequencer

This block sits at the root of a character display controller. It runs on the display oscillator clock and takes three inputs: a raw power-good level, a power-down control bit from the register logic, and a completion signal from the routine that blanks the display memory. From these it builds the chip-wide synchronous reset, a one-cycle request to start the clear routine, a busy level for the host-facing status bit, enables for the oscillator and the bias generator, a control that ties every segment and common driver to ground, and the frame-rate tick.

A loss of power-good forces the internal reset at once. On power-good return, reset is released to the rest of the chip only after a fixed count of oscillator cycles, and the clear request follows in the same cycle as the release. Setting the power-down bit stops the bias and oscillator, grounds the drivers and holds the whole chip in reset. Clearing the bit restarts the chip through the same reset and clear steps it takes at power-up. The frame tick divides the oscillator by a parameter whose default is 3072. It restarts from zero after every reset and stays silent during power-down. The oscillator enable comes back through a path that has no clock in it, so a stopped oscillator restarts as soon as power-down is released.

Top module: `disp_pwr_seq`

## Requirements
- R1: While `pwr_ok` is low, `rst_int_n` is 0, `busy` is 1, and `clr_start` and `frame_tick` are 0.
- R2: With `pd_req` low, `rst_int_n` rises on the 6th rising clock edge after `pwr_ok` rises. That is 2 synchronizer edges, 1 decision edge and exactly `RST_CYCLES`=3 reset cycles.
- R3: A fall of `pwr_ok` drives `rst_int_n` to 0 and `busy` to 1 without waiting for a clock edge.
- R4: `clr_start` is high for exactly one cycle after each reset release. It is the first cycle in which `rst_int_n` is high, and it does not pulse again until the next release.
- R5: `busy` stays 1 from reset until the first rising edge, after the request cycle, at which `clr_done` is 1. It then falls to 0. A `clr_done` level during reset or during the request cycle is ignored.
- R6: After `pd_req` rises, the 3rd rising edge sets `out_force_low` to 1, `bias_en` to 0, `rst_int_n` to 0 and `busy` to 1. All four hold while power-down lasts.
- R7: `osc_en` is 0 only while the sequencer is in power-down and `pd_req` is still 1. It returns to 1 as soon as `pd_req` falls, with no clock edge needed.
- R8: After `pd_req` falls, `rst_int_n` rises on the 6th rising edge and a new single `clr_start` pulse occurs, the same as at power-up.
- R9: `frame_tick` is a one-cycle pulse. Counting the first cycle with `rst_int_n` high as cycle 0, it is high in cycle `FRAME_DIV`-1 and then every `FRAME_DIV` cycles.
- R10: `frame_tick` is never high while `rst_int_n` is low. The divider restarts from zero after each reset, including the one that ends a power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Display oscillator clock |
| pwr_ok | input | 1 | Raw power-good, active high; a low level resets the block asynchronously |
| pd_req | input | 1 | Power-down control bit, asynchronous to `clk_osc` |
| clr_done | input | 1 | Level from the clear-display routine, 1 when finished |
| rst_int_n | output | 1 | Chip-wide synchronous reset, active low |
| clr_start | output | 1 | One-cycle request to start the clear-display routine |
| busy | output | 1 | 1 from reset until the clear routine reports done |
| osc_en | output | 1 | Oscillator enable |
| bias_en | output | 1 | Bias generator enable |
| out_force_low | output | 1 | 1 ties all segment and common outputs to ground |
| frame_tick | output | 1 | One-cycle pulse at the frame rate |

## Verification
The bench counts edges from a release to the rise of `rst_int_n`. A sequencer that lost a synchronizer stage or miscounted the reset window rises on the 5th or 7th edge instead of the 6th. The bench holds `clr_done` high through the reset window, so a design that listened too early would drop `busy` before any clear had run. It samples the oscillator enable one nanosecond after `pd_req` falls, which catches an enable that waits for a clock that may be stopped. It times the first frame tick after power-down exit, which exposes a divider that kept its count or ticked during power-down. A power-good drop checked without a clock edge shows whether the reset assert is really asynchronous.

// File: rtl/dps_pkg.sv
// Shared types for the display reset and power-down sequencer.
// Assumes nothing beyond the enum encodings being private to the block.
package dps_pkg;

    typedef enum logic [2:0] {
        SQ_HOLD    = 3'd0,  // waiting for power-good release
        SQ_PDN     = 3'd1,  // power-down: outputs grounded, chip in reset
        SQ_RESET   = 3'd2,  // counting the reset window
        SQ_CLRREQ  = 3'd3,  // single request cycle to the clear routine
        SQ_CLRWAIT = 3'd4,  // waiting for the clear routine to finish
        SQ_RUN     = 3'd5   // normal display operation
    } seq_state_t;

endpackage

// File: rtl/dps_por_sync.sv
// Power-good reset synchronizer: asserts asynchronously when pwr_ok falls,
// releases after STAGES rising edges of clk. Assumes pwr_ok is glitch-filtered.
module dps_por_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pwr_ok,
    output logic por_n
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Each stage clears at once on power loss and shifts a 1 in afterwards.
            always_ff @(posedge clk or negedge pwr_ok) begin
                if (!pwr_ok) chain[gi] <= 1'b0;
                else         chain[gi] <= (gi == 0) ? 1'b1 : chain[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    assign por_n = chain[STAGES-1];
endmodule

// File: rtl/dps_bit_sync.sv
// Plain multi-flop synchronizer for one level signal. No reset: the value
// settles STAGES edges after the clock starts. Assumes the input is a slow level.
module dps_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Shift the asynchronous level one stage further each edge.
            always_ff @(posedge clk) begin
                chain[gi] <= (gi == 0) ? d_async : chain[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dps_seq_fsm.sv
// Sequencing state machine: reset window, clear-display request and handshake,
// power-down entry and exit. Assumes por_n is already synchronous on release
// and pd_s is synchronized; pd_raw is used only on the clockless oscillator-enable path.
module dps_seq_fsm
    import dps_pkg::*;
#(
    parameter int RST_CYCLES = 3
) (
    input  logic clk,
    input  logic por_n,
    input  logic pd_s,
    input  logic pd_raw,
    input  logic clr_done,
    output logic rst_int_n,
    output logic clr_start,
    output logic busy,
    output logic osc_en,
    output logic bias_en,
    output logic out_force_low
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    seq_state_t state;
    logic [CW-1:0] rst_cnt;

    // State register with synchronous active-low reset from the power-good chain.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state   <= SQ_HOLD;
            rst_cnt <= '0;
        end else if (pd_s) begin
            state   <= SQ_PDN;
            rst_cnt <= '0;
        end else begin
            case (state)
                SQ_HOLD, SQ_PDN: begin
                    state   <= SQ_RESET;
                    rst_cnt <= '0;
                end
                SQ_RESET: begin
                    if (rst_cnt == LAST) state <= SQ_CLRREQ;
                    else                 rst_cnt <= rst_cnt + 1'b1;
                end
                SQ_CLRREQ:  state <= SQ_CLRWAIT;
                SQ_CLRWAIT: if (clr_done) state <= SQ_RUN;
                SQ_RUN:     state <= SQ_RUN;
                default:    state <= SQ_HOLD;
            endcase
        end
    end

    // Output decode; power loss overrides reset and busy without a clock.
    always_comb begin
        rst_int_n     = por_n && (state == SQ_CLRREQ || state == SQ_CLRWAIT || state == SQ_RUN);
        clr_start     = por_n && (state == SQ_CLRREQ);
        busy          = !por_n || (state != SQ_RUN);
        out_force_low = (state == SQ_PDN);
        bias_en       = (state != SQ_PDN);
        osc_en        = !((state == SQ_PDN) && pd_raw);
    end
endmodule

// File: rtl/dps_frame_div.sv
// Frame-rate divider: counts DIV oscillator cycles while enabled and marks the
// last one. Assumes en_n low clears it (reset and power-down both hold it).
module dps_frame_div #(
    parameter int DIV = 3072
) (
    input  logic clk,
    input  logic en_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] TOP = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Wrapping counter, held at zero whenever the chip is in reset.
    always_ff @(posedge clk) begin
        if (!en_n)          cnt <= '0;
        else if (cnt == TOP) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    // Tick decode gated by the enable so no pulse leaks into reset.
    assign tick = en_n && (cnt == TOP);
endmodule

// File: rtl/disp_pwr_seq.sv
// Top of the reset and power-down sequencer. Wires the power-good synchronizer,
// the power-down synchronizer, the sequencing FSM and the frame divider.
// Assumes clk_osc runs whenever the chip is not in power-down.
module disp_pwr_seq #(
    parameter int RST_CYCLES  = 3,
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_DIV   = 3072
) (
    input  logic clk_osc,
    input  logic pwr_ok,
    input  logic pd_req,
    input  logic clr_done,
    output logic rst_int_n,
    output logic clr_start,
    output logic busy,
    output logic osc_en,
    output logic bias_en,
    output logic out_force_low,
    output logic frame_tick
);
    logic por_n;
    logic pd_s;

    dps_por_sync #(.STAGES(SYNC_STAGES)) u_por (
        .clk    (clk_osc),
        .pwr_ok (pwr_ok),
        .por_n  (por_n)
    );

    dps_bit_sync #(.STAGES(SYNC_STAGES)) u_pdsync (
        .clk     (clk_osc),
        .d_async (pd_req),
        .q_sync  (pd_s)
    );

    dps_seq_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk           (clk_osc),
        .por_n         (por_n),
        .pd_s          (pd_s),
        .pd_raw        (pd_req),
        .clr_done      (clr_done),
        .rst_int_n     (rst_int_n),
        .clr_start     (clr_start),
        .busy          (busy),
        .osc_en        (osc_en),
        .bias_en       (bias_en),
        .out_force_low (out_force_low)
    );

    dps_frame_div #(.DIV(FRAME_DIV)) u_div (
        .clk  (clk_osc),
        .en_n (rst_int_n),
        .tick (frame_tick)
    );
endmodule

// File: rtl/dps_checker.sv
// Port-level property checker for disp_pwr_seq, attached by bind below.
// Assumes FRAME_DIV of at least 2.
module dps_checker (
    input logic clk_osc,
    input logic pwr_ok,
    input logic pd_req,
    input logic clr_done,
    input logic rst_int_n,
    input logic clr_start,
    input logic busy,
    input logic osc_en,
    input logic bias_en,
    input logic out_force_low,
    input logic frame_tick
);
    // R4: the clear request lasts one cycle.
    a_r4_clr_one_cycle: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        clr_start |=> !clr_start);

    // R4: the clear request coincides with the reset release.
    a_r4_clr_at_release: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        $rose(rst_int_n) |-> clr_start);

    // R2: the release is preceded by at least three low cycles.
    a_r2_reset_window: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        $rose(rst_int_n) |-> (!$past(rst_int_n, 2) && !$past(rst_int_n, 3)));

    // R5: busy only falls after the clear routine reported done.
    a_r5_busy_needs_done: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        $fell(busy) |-> $past(clr_done));

    // R6: grounded outputs come with bias off and the chip in reset.
    a_r6_pd_outputs: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        out_force_low |-> (!bias_en && !rst_int_n && busy));

    // R7: oscillator off only in power-down with the request still set.
    a_r7_osc_gate: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        !osc_en |-> (out_force_low && pd_req));

    // R9: the frame tick is a single-cycle pulse.
    a_r9_tick_single: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        frame_tick |=> !frame_tick);

    // R10: no frame tick while the chip is in reset.
    a_r10_no_tick_in_reset: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        !rst_int_n |-> !frame_tick);
endmodule

bind disp_pwr_seq dps_checker u_chk (
    .clk_osc       (clk_osc),
    .pwr_ok        (pwr_ok),
    .pd_req        (pd_req),
    .clr_done      (clr_done),
    .rst_int_n     (rst_int_n),
    .clr_start     (clr_start),
    .busy          (busy),
    .osc_en        (osc_en),
    .bias_en       (bias_en),
    .out_force_low (out_force_low),
    .frame_tick    (frame_tick)
);

// File: tb/tb_disp_pwr_seq.sv
// Directed bench for disp_pwr_seq: one task per scenario, each checks itself.
module tb_disp_pwr_seq;
    localparam int DIV = 3072;

    logic clk = 1'b0;
    logic pwr_ok = 1'b0;
    logic pd_req = 1'b0;
    logic clr_done = 1'b0;
    logic rst_int_n, clr_start, busy, osc_en, bias_en, out_force_low, frame_tick;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    disp_pwr_seq dut (
        .clk_osc       (clk),
        .pwr_ok        (pwr_ok),
        .pd_req        (pd_req),
        .clr_done      (clr_done),
        .rst_int_n     (rst_int_n),
        .clr_start     (clr_start),
        .busy          (busy),
        .osc_en        (osc_en),
        .bias_en       (bias_en),
        .out_force_low (out_force_low),
        .frame_tick    (frame_tick)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One rising edge, then sample point at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Counts edges until rst_int_n is seen high; leaves the bench at that sample.
    task automatic edges_to_release(output int n);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            n++;
            if (rst_int_n) break;
        end
    endtask

    task automatic t_power_on();
        int n;
        int pulses;
        for (int i = 0; i < 4; i++) step();
        chk(rst_int_n == 0, "R1 rst_int_n", rst_int_n, 0);
        chk(busy == 1, "R1 busy", busy, 1);
        chk(clr_start == 0 && frame_tick == 0, "R1 start/tick", {clr_start, frame_tick}, 0);
        pwr_ok = 1'b1;
        clr_done = 1'b1;   // R5: must be ignored during the reset window
        edges_to_release(n);
        chk(n == 6, "R2 edges to release", n, 6);
        chk(clr_start == 1, "R4 pulse at release", clr_start, 1);
        clr_done = 1'b0;
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (clr_start) pulses++;
        end
        chk(pulses == 0, "R4 no extra pulse", pulses, 0);
        chk(busy == 1, "R5 done during reset ignored", busy, 1);
    endtask

    task automatic t_clear_handshake(input string tag);
        chk(busy == 1, {tag, " busy before done"}, busy, 1);
        clr_done = 1'b1;
        step();
        clr_done = 1'b0;
        chk(busy == 0, {tag, " busy after done"}, busy, 0);
        for (int i = 0; i < 5; i++) step();
        chk(busy == 0, {tag, " busy stays low"}, busy, 0);
    endtask

    // Starts at the first sample with rst_int_n high (cycle 0).
    task automatic t_frame(input string tag);
        int first  = -1;
        int second = -1;
        int count  = 0;
        chk(frame_tick == 0, {tag, " no tick at cycle 0"}, frame_tick, 0);
        for (int i = 1; i <= 2 * DIV + DIV / 2; i++) begin
            step();
            if (frame_tick) begin
                count++;
                if (first < 0) first = i;
                else if (second < 0) second = i;
            end
        end
        chk(first == DIV - 1, {tag, " first tick"}, first, DIV - 1);
        chk(second == 2 * DIV - 1, {tag, " second tick"}, second, 2 * DIV - 1);
        chk(count == 2, {tag, " tick count"}, count, 2);
    endtask

    task automatic t_powerdown();
        int ticks = 0;
        pd_req = 1'b1;
        step();
        step();
        chk(out_force_low == 0 && osc_en == 1, "R6 not yet forced at edge 2", out_force_low, 0);
        step();
        chk(out_force_low == 1, "R6 forced low", out_force_low, 1);
        chk(bias_en == 0, "R6 bias off", bias_en, 0);
        chk(rst_int_n == 0 && busy == 1, "R6 chip in reset", {rst_int_n, busy}, 1);
        chk(osc_en == 0, "R7 oscillator off", osc_en, 0);
        for (int i = 0; i < DIV + 100; i++) begin
            step();
            if (frame_tick) ticks++;
        end
        chk(ticks == 0, "R10 no tick in power-down", ticks, 0);
        chk(out_force_low == 1 && bias_en == 0, "R6 held", out_force_low, 1);
    endtask

    task automatic t_pd_exit();
        int n;
        pd_req = 1'b0;
        #1;
        chk(osc_en == 1, "R7 oscillator on without edge", osc_en, 1);
        @(negedge clk);
        n = 1;
        if (!rst_int_n) begin
            int m;
            edges_to_release(m);
            n = n + m;
        end
        // pd_req fell half a cycle before the first edge, so edges counted from it
        chk(n == 6, "R8 edges to release", n, 6);
        chk(clr_start == 1, "R8 clear request again", clr_start, 1);
        chk(out_force_low == 0 && bias_en == 1, "R8 outputs released", out_force_low, 0);
    endtask

    task automatic t_brownout();
        int n;
        pwr_ok = 1'b0;
        #1;
        chk(rst_int_n == 0, "R3 async reset", rst_int_n, 0);
        chk(busy == 1, "R3 async busy", busy, 1);
        @(negedge clk);
        step();
        chk(frame_tick == 0 && clr_start == 0, "R1 quiet in reset", {frame_tick, clr_start}, 0);
        pwr_ok = 1'b1;
        edges_to_release(n);
        chk(n == 6, "R2 release after brownout", n, 6);
    endtask

    initial begin
        @(negedge clk);
        t_power_on();
        // t_power_on left the bench 20 cycles after release; restart by power-down
        t_powerdown();
        t_pd_exit();
        t_frame("R9");
        t_clear_handshake("R5");
        t_powerdown();
        t_pd_exit();
        t_frame("R10 restart");
        t_brownout();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule